// File: doc/BRIEF.md
# Hot-Line Parity Guard

This block guards an unprotected data cache whose arrays hold no check bits of their own. It keeps a small fully associative table. Each valid entry records a cache line address, the parity code of that line's current contents and a saturating use counter. Table slots go to the lines the cache touches most often. Lines that hold no slot pass through without any check.

Every request carries a line address, a 64-bit data word and an operation code. On a read, the block looks the line up. On a hit it regenerates byte parity from the returned data, compares it with the stored code, and reports a per-byte mismatch vector one cycle later. Writes and fills to a resident line refresh its code. On a miss, a fill always claims a slot and a write claims one only under an allocation rule. An eviction notice from the cache clears the matching slot, so that an old code never judges new data. The code generator groups the data into GROUP_W-bit chunks. A different group size changes the code without touching the table.

Top module: `hotline_guard`

## Requirements
- R1: Reset (synchronous, active high) empties the table, and chk_hit, chk_checked and chk_err all read zero on the first cycle after reset is released.
- R2: The operation code is 2'b00 read, 2'b01 write, 2'b10 fill and 2'b11 evict. A read to a resident line gives chk_hit=1 and chk_checked=1 in the next cycle. In that cycle bit b of chk_err equals the stored code bit b XOR the even parity of data bits [8b+7:8b]. The outputs hold these values for that one cycle only.
- R3: A read to a line with no slot gives chk_hit=0, chk_checked=0 and chk_err=0 in the next cycle, and it leaves the table unchanged.
- R4: A write to a resident line replaces its stored code with the parity of the written data in that same cycle. Its outputs are chk_hit=1, chk_checked=0 and chk_err=0.
- R5: A write miss claims the victim slot if that slot is empty or if its counter is strictly below alloc_limit. Otherwise the write changes nothing.
- R6: A fill to a resident line refreshes its code. A fill miss always claims the victim slot, whatever alloc_limit holds.
- R7: The victim is the lowest-numbered empty slot. When no slot is empty, it is the slot with the smallest counter, and the lowest number wins a tie. No two valid slots ever hold the same line.
- R8: A newly claimed slot starts its counter at 1. Every read, write or fill hit adds 1, and the counter saturates at its all-ones value.
- R9: An evict to a resident line empties that slot and clears its counter, so that later reads of the line miss. An evict to a line with no slot has no effect.
- R10: chk_checked is raised only for read hits. chk_err is zero whenever chk_checked is zero, including after every write, fill and evict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | 00 read, 01 write, 10 fill, 11 evict |
| req_line | input | ADDR_W (29) | Cache line address |
| req_data | input | DATA_W (64) | Data read from or written to the line |
| alloc_limit | input | CNT_W (4) | Counter bound below which a write miss may displace a slot |
| chk_hit | output | 1 | Previous request found its line in the table |
| chk_checked | output | 1 | Previous request was a read that was checked |
| chk_err | output | DATA_W/GROUP_W (8) | Per-group parity mismatch of the checked read |

## Verification
The bench builds the block with 4 slots, 6-bit line addresses, 16-bit data in two byte groups and 2-bit counters. This makes the table fill up, saturate counters and run out of empty slots within a few requests, so every victim and threshold case comes into reach. With this data width, reads can sweep all 65,536 data words against the stored codes, which covers every single-bit and multi-bit mismatch pattern in both groups. A long pseudo-random mix of all four operations over eight lines, with alloc_limit changing on every request, is then compared with a model of the table that is built from the requirements alone.

// File: rtl/hlg_pkg.sv
package hlg_pkg;

  typedef enum logic [1:0] {
    OP_READ  = 2'b00,
    OP_WRITE = 2'b01,
    OP_FILL  = 2'b10,
    OP_EVICT = 2'b11
  } hlg_op_e;

endpackage

// File: rtl/hlg_codegen.sv
// Check-code generator: one even-parity bit per GROUP_W-bit slice of the data.
module hlg_codegen #(
  parameter int DATA_W  = 64,
  parameter int GROUP_W = 8,
  localparam int CODE_W = DATA_W / GROUP_W
) (
  input  logic [DATA_W-1:0] data,
  output logic [CODE_W-1:0] code
);

  for (genvar g = 0; g < CODE_W; g++) begin : g_grp
    assign code[g] = ^data[g*GROUP_W +: GROUP_W];
  end

endmodule

// File: rtl/hlg_tagmatch.sv
// Parallel comparison of the request line against every valid slot.
module hlg_tagmatch #(
  parameter int ENTRIES = 64,
  parameter int ADDR_W  = 29,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0]             vld,
  input  logic [ENTRIES-1:0][ADDR_W-1:0] tags,
  input  logic [ADDR_W-1:0]              key,
  output logic [ENTRIES-1:0]             match,
  output logic                           hit,
  output logic [IDX_W-1:0]               idx
);

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign match[i] = vld[i] && (tags[i] == key);
  end

  assign hit = |match;

  // Lines are unique in the table, so the match is one-hot and an OR of indices suffices.
  always_comb begin
    idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match[i]) idx = idx | IDX_W'(i);
    end
  end

endmodule

// File: rtl/hlg_victim.sv
// Victim picker: an empty slot first, else the smallest counter; lowest index wins ties.
module hlg_victim #(
  parameter int ENTRIES = 64,
  parameter int CNT_W   = 4,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0]            vld,
  input  logic [ENTRIES-1:0][CNT_W-1:0] cnt,
  output logic [IDX_W-1:0]              vic_idx,
  output logic                          vic_vld,
  output logic [CNT_W-1:0]              vic_cnt
);

  logic [CNT_W:0] best_key;

  // Rank key {valid, count}: empty slots carry count zero, so they rank below every valid slot.
  always_comb begin
    vic_idx  = '0;
    best_key = {vld[0], cnt[0]};
    for (int i = 1; i < ENTRIES; i++) begin
      if ({vld[i], cnt[i]} < best_key) begin
        vic_idx  = IDX_W'(i);
        best_key = {vld[i], cnt[i]};
      end
    end
  end

  assign vic_vld = best_key[CNT_W];
  assign vic_cnt = best_key[CNT_W-1:0];

endmodule

// File: rtl/hotline_guard.sv
module hotline_guard
  import hlg_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int ADDR_W  = 29,
  parameter int DATA_W  = 64,
  parameter int GROUP_W = 8,
  parameter int CNT_W   = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        req_valid,
  input  logic [1:0]                  req_op,
  input  logic [ADDR_W-1:0]           req_line,
  input  logic [DATA_W-1:0]           req_data,
  input  logic [CNT_W-1:0]            alloc_limit,
  output logic                        chk_hit,
  output logic                        chk_checked,
  output logic [DATA_W/GROUP_W-1:0]   chk_err
);

  localparam int CODE_W = DATA_W / GROUP_W;
  localparam int IDX_W  = $clog2(ENTRIES);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  // Slot state: valid and counters are reset; tag and code arrays are plain storage.
  logic [ENTRIES-1:0]             ent_vld;
  logic [ENTRIES-1:0][CNT_W-1:0]  ent_cnt;
  logic [ENTRIES-1:0][ADDR_W-1:0] ent_tag;
  logic [ENTRIES-1:0][CODE_W-1:0] ent_par;

  hlg_op_e            op;
  logic [CODE_W-1:0]  new_code;
  logic [ENTRIES-1:0] hit_vec;
  logic               hit;
  logic [IDX_W-1:0]   hit_idx;
  logic [IDX_W-1:0]   vic_idx;
  logic               vic_vld;
  logic [CNT_W-1:0]   vic_cnt;
  logic [CNT_W-1:0]   hit_cnt;
  logic [CNT_W-1:0]   cnt_next;
  logic               do_bump, do_code, do_alloc, do_drop, do_check;

  assign op = hlg_op_e'(req_op);

  hlg_codegen #(.DATA_W(DATA_W), .GROUP_W(GROUP_W)) u_code (
    .data (req_data),
    .code (new_code)
  );

  hlg_tagmatch #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_match (
    .vld   (ent_vld),
    .tags  (ent_tag),
    .key   (req_line),
    .match (hit_vec),
    .hit   (hit),
    .idx   (hit_idx)
  );

  hlg_victim #(.ENTRIES(ENTRIES), .CNT_W(CNT_W)) u_vic (
    .vld     (ent_vld),
    .cnt     (ent_cnt),
    .vic_idx (vic_idx),
    .vic_vld (vic_vld),
    .vic_cnt (vic_cnt)
  );

  // Decide what the current request does to the table.
  always_comb begin
    hit_cnt  = ent_cnt[hit_idx];
    cnt_next = (hit_cnt == CNT_MAX) ? hit_cnt : hit_cnt + 1'b1;
    do_bump  = req_valid && hit && (op != OP_EVICT);
    do_code  = req_valid && hit && ((op == OP_WRITE) || (op == OP_FILL));
    do_drop  = req_valid && hit && (op == OP_EVICT);
    do_check = req_valid && hit && (op == OP_READ);
    do_alloc = req_valid && !hit &&
               ((op == OP_FILL) ||
                ((op == OP_WRITE) && (!vic_vld || (vic_cnt < alloc_limit))));
  end

  // Valid bits and use counters.
  always_ff @(posedge clk) begin
    if (rst) begin
      ent_vld <= '0;
      ent_cnt <= '0;
    end else begin
      if (do_bump) ent_cnt[hit_idx] <= cnt_next;
      if (do_drop) begin
        ent_vld[hit_idx] <= 1'b0;
        ent_cnt[hit_idx] <= '0;
      end
      if (do_alloc) begin
        ent_vld[vic_idx] <= 1'b1;
        ent_cnt[vic_idx] <= CNT_W'(1);
      end
    end
  end

  // Tag and code storage, one write port, no reset.
  always_ff @(posedge clk) begin
    if (do_code) ent_par[hit_idx] <= new_code;
    if (do_alloc) begin
      ent_tag[vic_idx] <= req_line;
      ent_par[vic_idx] <= new_code;
    end
  end

  // Registered status.
  always_ff @(posedge clk) begin
    if (rst) begin
      chk_hit     <= 1'b0;
      chk_checked <= 1'b0;
      chk_err     <= '0;
    end else begin
      chk_hit     <= req_valid && hit;
      chk_checked <= do_check;
      chk_err     <= do_check ? (ent_par[hit_idx] ^ new_code) : '0;
    end
  end

  // R1: status is quiet right after reset.
  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!chk_hit && !chk_checked && (chk_err == '0)))
    else $error("a_r1_quiet_after_reset");

  // R2: a checked result always stems from a read request one cycle earlier.
  a_r2_checked_from_read: assert property (@(posedge clk) disable iff (rst)
    chk_checked |-> $past(req_valid && (req_op == 2'b00)))
    else $error("a_r2_checked_from_read");

  // R10: mismatch bits only accompany a checked read.
  a_r10_err_needs_check: assert property (@(posedge clk) disable iff (rst)
    (chk_err != '0) |-> chk_checked)
    else $error("a_r10_err_needs_check");

  // R10: a checked read was a hit.
  a_r10_checked_is_hit: assert property (@(posedge clk) disable iff (rst)
    chk_checked |-> chk_hit)
    else $error("a_r10_checked_is_hit");

  // R7: a line never resides in two slots.
  a_r7_unique_tags: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit_vec))
    else $error("a_r7_unique_tags");

  // R8: every valid slot carries a non-zero counter.
  for (genvar i = 0; i < ENTRIES; i++) begin : g_cnt_chk
    a_r8_live_count: assert property (@(posedge clk) disable iff (rst)
      ent_vld[i] |-> (ent_cnt[i] != '0))
      else $error("a_r8_live_count");
  end

endmodule

// File: tb/sim_hotline_guard.sv
module sim_hotline_guard;

  localparam int E = 4;
  localparam int A = 6;
  localparam int D = 16;
  localparam int G = 8;
  localparam int C = D / G;
  localparam int W = 2;

  logic         clk = 1'b0;
  logic         rst;
  logic         req_valid;
  logic [1:0]   req_op;
  logic [A-1:0] req_line;
  logic [D-1:0] req_data;
  logic [W-1:0] alloc_limit;
  logic         chk_hit;
  logic         chk_checked;
  logic [C-1:0] chk_err;

  always #10 clk = ~clk;

  hotline_guard #(.ENTRIES(E), .ADDR_W(A), .DATA_W(D), .GROUP_W(G), .CNT_W(W)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op), .req_line(req_line),
    .req_data(req_data), .alloc_limit(alloc_limit), .chk_hit(chk_hit),
    .chk_checked(chk_checked), .chk_err(chk_err)
  );

  int n_tests = 0;
  int n_fail  = 0;

  // Table model built from the requirements.
  logic         mv [E];
  logic [A-1:0] mt [E];
  logic [C-1:0] mp [E];
  logic [W-1:0] mc [E];

  function automatic logic [C-1:0] code_of(logic [D-1:0] d);
    logic [C-1:0] c;
    for (int b = 0; b < C; b++) c[b] = ^d[b*G +: G];
    return c;
  endfunction

  function automatic int find_line(logic [A-1:0] a);
    for (int i = 0; i < E; i++) if (mv[i] && mt[i] == a) return i;
    return -1;
  endfunction

  function automatic int pick_victim();
    int best = 0;
    for (int i = 1; i < E; i++)
      if ({mv[i], mc[i]} < {mv[best], mc[best]}) best = i;
    return best;
  endfunction

  task automatic model_clear();
    for (int i = 0; i < E; i++) begin mv[i] = 1'b0; mc[i] = '0; end
  endtask

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  // Drive one request at a falling edge, check the registered status one cycle later.
  task automatic do_op(logic [1:0] op, logic [A-1:0] a, logic [D-1:0] d, string why);
    int h, v;
    logic e_hit, e_chk;
    logic [C-1:0] e_err;
    string tag;
    req_valid = 1'b1; req_op = op; req_line = a; req_data = d;
    h = find_line(a);
    e_hit = (h >= 0);
    e_chk = (op == 2'b00) && e_hit;
    e_err = e_chk ? (mp[h] ^ code_of(d)) : '0;
    case (op)
      2'b00: tag = e_hit ? "R2" : "R3";
      2'b01: tag = e_hit ? "R4" : "R5";
      2'b10: tag = "R6";
      default: tag = "R9";
    endcase
    if (e_hit) begin
      if (op == 2'b11) begin
        mv[h] = 1'b0; mc[h] = '0;
      end else begin
        if (mc[h] != '1) mc[h] = mc[h] + 1'b1;
        if (op != 2'b00) mp[h] = code_of(d);
      end
    end else if (op == 2'b10 || op == 2'b01) begin
      v = pick_victim();
      if (op == 2'b10 || !mv[v] || mc[v] < alloc_limit) begin
        mv[v] = 1'b1; mt[v] = a; mp[v] = code_of(d); mc[v] = W'(1);
      end
    end
    @(negedge clk);
    req_valid = 1'b0;
    check({tag, " R10 ", why}, {29'd0, chk_hit, chk_checked, chk_err[1], 1'b0} | 32'(chk_err),
          {29'd0, e_hit, e_chk, e_err[1], 1'b0} | 32'(e_err));
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst = 1'b1; req_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    model_clear();
    @(negedge clk);
    check("R1 status after reset", {29'd0, chk_hit, chk_checked, chk_err}, 32'd0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got running expected done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] s;
    logic [A-1:0] pool [4];
    rst = 1'b1; req_valid = 1'b0; req_op = '0; req_line = '0; req_data = '0;
    alloc_limit = '0;
    model_clear();
    apply_reset();

    // R1, R3: every line misses in an empty table.
    for (int a = 0; a < (1 << A); a++) do_op(2'b00, A'(a), D'(a * 97), "R1 empty read");

    // R6, R7, R8: fills claim empty slots in order; line 1 reads three times to saturate.
    do_op(2'b10, 6'd1, 16'h1234, "fill");
    do_op(2'b10, 6'd2, 16'h00ff, "fill");
    do_op(2'b10, 6'd3, 16'h8001, "fill");
    do_op(2'b10, 6'd4, 16'h0000, "fill");
    do_op(2'b00, 6'd1, 16'h1234, "R8 count");
    do_op(2'b00, 6'd1, 16'h1234, "R8 count");
    do_op(2'b00, 6'd1, 16'h1234, "R8 saturate");
    // R7: slots 1..3 tie at count 1, so slot 1 (line 2) is displaced.
    alloc_limit = 2'd2;
    do_op(2'b01, 6'd5, 16'h0f0f, "R7 tie lowest index");
    do_op(2'b00, 6'd2, 16'h00ff, "R7 displaced line");
    do_op(2'b00, 6'd3, 16'h8001, "R7 survivor");
    // R5: smallest count 1 is not below limit 1, no allocation.
    alloc_limit = 2'd1;
    do_op(2'b01, 6'd6, 16'haaaa, "R5 blocked");
    do_op(2'b00, 6'd6, 16'haaaa, "R5 blocked read");
    do_op(2'b00, 6'd5, 16'h0f0f, "R5 earlier claim");
    // R9: evict frees a slot; a write miss then claims it even with limit 0.
    alloc_limit = 2'd0;
    do_op(2'b11, 6'd4, 16'h0000, "R9 evict");
    do_op(2'b11, 6'd9, 16'h0000, "R9 absent evict");
    do_op(2'b00, 6'd4, 16'h0000, "R9 read after evict");
    do_op(2'b01, 6'd7, 16'h0101, "R5 empty slot");
    do_op(2'b00, 6'd7, 16'h0101, "R5 empty slot read");
    // R4: write hit replaces the code; stale data now mismatches.
    do_op(2'b01, 6'd3, 16'h00ff, "R4 write hit");
    do_op(2'b00, 6'd3, 16'h00ff, "R4 new code");
    do_op(2'b00, 6'd3, 16'h8001, "R4 old data");
    // R6: fill hit refreshes, fill miss displaces even with limit 0.
    do_op(2'b10, 6'd5, 16'h0001, "R6 fill hit");
    do_op(2'b10, 6'd8, 16'h0003, "R6 fill miss");

    // R2: sweep every data word against the four resident lines.
    pool[0] = 6'd1; pool[1] = 6'd3; pool[2] = 6'd5; pool[3] = 6'd8;
    for (int x = 0; x < (1 << D); x++) do_op(2'b00, pool[x % 4], D'(x), "R2 sweep");

    // Mixed traffic, R2..R10.
    apply_reset();
    s = 32'h1ace_b00c;
    for (int k = 0; k < 20000; k++) begin
      s = s * 32'd1664525 + 32'd1013904223;
      alloc_limit = s[13:12];
      do_op(s[9:8], {3'b000, s[22:20]}, s[31:16], "mixed");
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule